// File: doc/BRIEF.md
# Segmented DAC Input Decoder

This block is the digital front end of a 12-bit current-steering converter. A parallel input word is captured on each rising clock edge. On the following edge the captured word is split and driven to the switch matrix. The upper 5 bits become 31 unary segment enables of equal weight, in thermometer order. The lower 7 bits pass straight through as binary-weighted enables. Every switch gets a pair of steering controls, one toward output A and one toward output B. When the block is awake, the B controls are the complement of the A controls.

A sleep input darkens every switch on both sides, while the capture register keeps running. Two behavioural current codes, one for each output, are derived from the driven enables. They exist so that checks can reason in LSB units rather than about the switch pattern. Sample conversion runs on every clock and the input cannot be stalled, so the data path has no valid/ready handshake and no back-pressure. Control pins are plain levels.

Top module: `dac_seg_front`

## Requirements
- R1: `word_in` is a 12-bit unsigned word with bit 11 as the most significant bit. With the block awake, `code_a` equals the word being driven.
- R2: The input is sampled only at the rising clock edge. Values that `word_in` takes between edges never reach the outputs.
- R3: A word present at rising edge N is captured at N and reaches all outputs after rising edge N+1. After edge N alone, the outputs still show the previously captured word.
- R4: For a driven word whose upper field (bits 11..7) holds k, `seg_en_a` bits 0..k-1 are 1 and bits k..30 are 0.
- R5: `bin_en_a` equals bits 6..0 of the driven word, bit i having weight 2^i.
- R6: While awake, `seg_en_b` is the bitwise complement of `seg_en_a`, and `bin_en_b` is the bitwise complement of `bin_en_a`.
- R7: Word 4095 drives every A enable to 1 and every B enable to 0, giving `code_a`=4095 and `code_b`=0. Word 0 gives the mirror image, with `code_a`=0 and `code_b`=4095.
- R8: While awake, `code_a` + `code_b` = 4095.
- R9: If `sleep` is 1 at a rising edge, then after that edge all four enable buses are 0, and `code_a` and `code_b` are 0.
- R10: Capture continues during sleep. Take the first edge at which `sleep` is 0 after a sleep period. After that edge, the outputs show the word captured at the preceding edge.
- R11: `rst` is synchronous and active high, and it takes priority over `sleep`. It clears both pipeline stages, so the outputs show the state for word 0 (`code_a`=0, `code_b`=4095, B enables all 1). After release, word 0 is still driven for one more cycle.
- R12: Each code is (number of set segment enables) × 128 + the binary enable value, taken on its own side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sleep | input | 1 | Power-down request, active high |
| word_in | input | 12 | Sample word, bit 11 most significant |
| seg_en_a | output | 31 | Unary segment enables steering to output A |
| seg_en_b | output | 31 | Unary segment enables steering to output B |
| bin_en_a | output | 7 | Binary-weighted enables steering to output A |
| bin_en_b | output | 7 | Binary-weighted enables steering to output B |
| code_a | output | 12 | Behavioural current code of output A in LSBs |
| code_b | output | 12 | Behavioural current code of output B in LSBs |

## Verification
Release from sleep and the capture of a new word can fall on the same edge. The bench drops `sleep` on the same edge that a fresh word is presented. It then expects the word captured during the last dark cycle first and the fresh word one cycle later. Reset and sleep can also coincide. The bench asserts both together, expects the reset state rather than the dark state, and then expects darkness once reset alone is released. Every one of the 4096 words is swept twice, once in ascending order and once in a permuted order, and each output is compared with arithmetic expectations.

// File: rtl/dac_seg_pkg.sv
package dac_seg_pkg;

  localparam int unsigned DEF_DATA_W = 12;
  localparam int unsigned DEF_BIN_W  = 7;

  // State of the output stage as seen by the checks
  typedef enum logic {
    STEER_RUN  = 1'b0,
    STEER_DARK = 1'b1
  } steer_mode_e;

endpackage

// File: rtl/dac_in_reg.sv
module dac_in_reg #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end

endmodule

// File: rtl/dac_therm_dec.sv
module dac_therm_dec #(
  parameter int unsigned SEG_BITS = 5,
  localparam int unsigned SEG_N   = (1 << SEG_BITS) - 1
) (
  input  logic [SEG_BITS-1:0] upper,
  output logic [SEG_N-1:0]    therm
);

  // Segment i is lit when the field value exceeds i
  for (genvar i = 0; i < SEG_N; i++) begin : g_seg
    assign therm[i] = (upper > SEG_BITS'(i));
  end

  // R4: the number of lit segments matches the field, and they form a contiguous run from bit 0
  always_comb begin
    if (!$isunknown(upper)) begin
      assert_therm_count_R4: assert ($countones(therm) == int'(upper));
      assert_therm_shape_R4: assert ((therm & (therm + SEG_N'(1))) == '0);
    end
  end

endmodule

// File: rtl/dac_steer_stage.sv
module dac_steer_stage
  import dac_seg_pkg::*;
#(
  parameter int unsigned SEG_N = 31,
  parameter int unsigned BIN_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sleep,
  input  logic [SEG_N-1:0] therm,
  input  logic [BIN_W-1:0] bin_in,
  output logic [SEG_N-1:0] seg_a,
  output logic [SEG_N-1:0] seg_b,
  output logic [BIN_W-1:0] bin_a,
  output logic [BIN_W-1:0] bin_b
);

  steer_mode_e mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_a <= '0;
      bin_a <= '0;
      seg_b <= '1;
      bin_b <= '1;
      mode  <= STEER_RUN;
    end else if (sleep) begin
      seg_a <= '0;
      bin_a <= '0;
      seg_b <= '0;
      bin_b <= '0;
      mode  <= STEER_DARK;
    end else begin
      seg_a <= therm;
      bin_a <= bin_in;
      seg_b <= ~therm;
      bin_b <= ~bin_in;
      mode  <= STEER_RUN;
    end
  end

  assert_b_mirror_R6: assert property (@(posedge clk) disable iff (rst)
    (mode == STEER_RUN) |-> (seg_b == ~seg_a && bin_b == ~bin_a));

  assert_dark_R9: assert property (@(posedge clk) disable iff (rst)
    (mode == STEER_DARK) |-> (seg_a == '0 && seg_b == '0 && bin_a == '0 && bin_b == '0));

  assert_rst_state_R11: assert property (@(posedge clk)
    rst |=> (seg_a == '0 && bin_a == '0 && seg_b == '1 && bin_b == '1));

endmodule

// File: rtl/dac_code_sum.sv
module dac_code_sum #(
  parameter int unsigned SEG_N  = 31,
  parameter int unsigned BIN_W  = 7,
  parameter int unsigned CODE_W = 12,
  localparam int unsigned CNT_W = $clog2(SEG_N + 1)
) (
  input  logic [SEG_N-1:0]  seg,
  input  logic [BIN_W-1:0]  bin,
  output logic [CODE_W-1:0] code
);

  logic [CNT_W-1:0] cnt;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < SEG_N; i++) cnt = cnt + CNT_W'(seg[i]);
  end

  // R12: each segment carries 2**BIN_W LSBs
  assign code = (CODE_W'(cnt) << BIN_W) | CODE_W'(bin);

endmodule

// File: rtl/dac_seg_front.sv
module dac_seg_front #(
  parameter int unsigned DATA_W = dac_seg_pkg::DEF_DATA_W,
  parameter int unsigned BIN_W  = dac_seg_pkg::DEF_BIN_W,
  localparam int unsigned SEG_BITS = DATA_W - BIN_W,
  localparam int unsigned SEG_N    = (1 << SEG_BITS) - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep,
  input  logic [DATA_W-1:0] word_in,
  output logic [SEG_N-1:0]  seg_en_a,
  output logic [SEG_N-1:0]  seg_en_b,
  output logic [BIN_W-1:0]  bin_en_a,
  output logic [BIN_W-1:0]  bin_en_b,
  output logic [DATA_W-1:0] code_a,
  output logic [DATA_W-1:0] code_b
);

  localparam int FULL = (1 << DATA_W) - 1;

  logic [DATA_W-1:0] cap_q;
  logic [SEG_N-1:0]  therm;

  dac_in_reg #(.W(DATA_W)) u_cap (
    .clk (clk),
    .rst (rst),
    .d   (word_in),
    .q   (cap_q)
  );

  dac_therm_dec #(.SEG_BITS(SEG_BITS)) u_dec (
    .upper (cap_q[DATA_W-1:BIN_W]),
    .therm (therm)
  );

  dac_steer_stage #(.SEG_N(SEG_N), .BIN_W(BIN_W)) u_steer (
    .clk    (clk),
    .rst    (rst),
    .sleep  (sleep),
    .therm  (therm),
    .bin_in (cap_q[BIN_W-1:0]),
    .seg_a  (seg_en_a),
    .seg_b  (seg_en_b),
    .bin_a  (bin_en_a),
    .bin_b  (bin_en_b)
  );

  dac_code_sum #(.SEG_N(SEG_N), .BIN_W(BIN_W), .CODE_W(DATA_W)) u_sum_a (
    .seg  (seg_en_a),
    .bin  (bin_en_a),
    .code (code_a)
  );

  dac_code_sum #(.SEG_N(SEG_N), .BIN_W(BIN_W), .CODE_W(DATA_W)) u_sum_b (
    .seg  (seg_en_b),
    .bin  (bin_en_b),
    .code (code_b)
  );

  // Edges since reset, saturating at 2, so the checks never look back past reset
  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (rst)            warm <= 2'd0;
    else if (warm != 2) warm <= warm + 2'd1;
  end

  assert_latency_R3: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd2 && !$past(sleep)) |-> (code_a == $past(word_in, 2)));

  assert_sum_R8: assert property (@(posedge clk) disable iff (rst)
    (warm != 2'd0 && !$past(sleep)) |-> ((int'(code_a) + int'(code_b)) == FULL));

  assert_dark_codes_R9: assert property (@(posedge clk) disable iff (rst)
    (warm != 2'd0 && $past(sleep)) |-> (code_a == '0 && code_b == '0));

endmodule

// File: tb/tb_dac_seg_front.sv
`timescale 1ns/1ps
module tb_dac_seg_front;

  logic        clk = 1'b0;
  logic        rst;
  logic        sleep;
  logic [11:0] word_in;
  logic [30:0] seg_a, seg_b;
  logic [6:0]  bin_a, bin_b;
  logic [11:0] code_a, code_b;
  int n_run  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  dac_seg_front dut (
    .clk      (clk),
    .rst      (rst),
    .sleep    (sleep),
    .word_in  (word_in),
    .seg_en_a (seg_a),
    .seg_en_b (seg_b),
    .bin_en_a (bin_a),
    .bin_en_b (bin_b),
    .code_a   (code_a),
    .code_b   (code_b)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected outputs for an awake stage driving word w
  task automatic check_word(input int unsigned w);
    int unsigned k = w >> 7;
    logic [63:0] sa = (64'd1 << k) - 64'd1;
    logic [63:0] ba = 64'(w & 127);
    chk("R4 seg_en_a", 64'(seg_a), sa);
    chk("R5 bin_en_a", 64'(bin_a), ba);
    chk("R6 seg_en_b", 64'(seg_b), ~sa & 64'h7FFF_FFFF);
    chk("R6 bin_en_b", 64'(bin_b), ~ba & 64'h7F);
    chk("R1 R3 R12 code_a", 64'(code_a), 64'(w));
    chk("R12 code_b", 64'(code_b), 64'(4095 - w));
    chk("R8 sum", 64'(code_a) + 64'(code_b), 64'd4095);
    if (w == 4095) chk("R7 full scale on A", {code_b, code_a, 1'b0, seg_b}, {12'd0, 12'd4095, 32'd0});
    if (w == 0)    chk("R7 full scale on B", {code_b, code_a, 1'b0, seg_a}, {12'd4095, 12'd0, 32'd0});
  endtask

  task automatic check_dark();
    chk("R9 enables dark", {33'd0, seg_a, seg_b, bin_a, bin_b}, 64'd0);
    chk("R9 codes dark", 64'({code_a, code_b}), 64'd0);
  endtask

  function automatic int unsigned seq(input int pass, input int unsigned i);
    return (pass == 0) ? i : ((i * 2731) & 4095);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; sleep = 1'b0; word_in = 12'hABC;
    repeat (3) @(negedge clk);
    // R11: reset state equals word 0
    check_word(0);
    chk("R11 reset code_b", 64'(code_b), 64'd4095);
    rst = 1'b0;

    // Exhaustive sweeps, ascending then permuted
    for (int pass = 0; pass < 2; pass++) begin
      for (int unsigned i = 0; i < 4098; i++) begin
        if (i >= 2) check_word(seq(pass, i - 2));
        word_in = (i < 4096) ? 12'(seq(pass, i)) : 12'd0;
        @(negedge clk);
      end
    end

    // R3: one edge is not enough
    word_in = 12'h5A3;
    @(negedge clk);
    chk("R3 after one edge", 64'(code_a), 64'd0);
    word_in = 12'h1C4;
    @(negedge clk);
    chk("R3 after two edges", 64'(code_a), 64'h5A3);
    @(negedge clk);
    check_word(12'h1C4);

    // R2: mid-cycle changes never sampled
    word_in = 12'hABC;
    @(posedge clk);
    #1 word_in = 12'h321;
    #1 word_in = 12'h0F0;
    @(negedge clk);
    @(negedge clk);
    chk("R2 first word", 64'(code_a), 64'hABC);
    @(negedge clk);
    chk("R2 no glitch word", 64'(code_a), 64'h0F0);

    // R9 / R10: sleep, capture continues, release coincides with new word
    sleep = 1'b1; word_in = 12'h7E1;
    @(negedge clk);
    check_dark();
    word_in = 12'h234;
    @(negedge clk);
    check_dark();
    sleep = 1'b0; word_in = 12'hC0F;
    @(negedge clk);
    chk("R10 word captured while dark", 64'(code_a), 64'h234);
    check_word(12'h234);
    @(negedge clk);
    chk("R10 next word", 64'(code_a), 64'hC0F);

    // R11: reset beats sleep
    rst = 1'b1; sleep = 1'b1; word_in = 12'h999;
    @(negedge clk);
    chk("R11 reset over sleep", {52'd0, code_b}, 64'd4095);
    chk("R11 reset seg_b", 64'(seg_b), 64'h7FFF_FFFF);
    rst = 1'b0; word_in = 12'h456;
    @(negedge clk);
    check_dark();
    sleep = 1'b0; word_in = 12'd0;
    @(negedge clk);
    chk("R10 after reset and sleep", 64'(code_a), 64'h456);

    // R11: both stages cleared
    rst = 1'b1; word_in = 12'hFFF;
    @(negedge clk);
    rst = 1'b0; word_in = 12'h800;
    @(negedge clk);
    chk("R11 capture stage cleared", 64'(code_a), 64'd0);
    @(negedge clk);
    check_word(12'h800);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule